// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous request port and an external asynchronous static RAM of 512K words by 16 bits with two byte lanes. A request carries a word address, write data, a per-lane enable mask and a read/write flag. It is taken under a valid/ready handshake. The controller then plays out the pin sequence for that access. It holds the address, the lane enables and the write data steady on the memory pins until the access completes. Read data returns with a single-cycle valid pulse.

The memory sees two chip selects of opposite polarity, an active-low write strobe, an active-low output enable and one active-low enable per byte lane. The shared data bus is split into an output value, an output-enable and an input value. All timing comes from nanosecond limits, converted to clock counts by rounding up against `CLK_PERIOD_NS`:

- Read access: 70 ns, so 7 cycles at the default 10 ns clock.
- Write strobe: the larger of the 50 ns pulse and the 30 ns data setup, so 5 cycles.
- Whole write: 70 ns, so 7 cycles.
- Bus release after a read: 25 ns, so 3 cycles.

Writes are timed by the write strobe, with zero address setup and zero recovery.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset, `mem_sel_n`=1, `mem_sel`=0, `mem_we_n`=1, `mem_oe_n`=1, both `mem_lane_n` bits are 1, `mem_dq_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the access and any release gap are over: 7+1+3 cycles for a read and 7+1 cycles for a write at the defaults.
- R3: While selected (`mem_sel_n`=0 with `mem_sel`=1), `mem_addr` equals the accepted address and `mem_lane_n[i]` equals the inverse of `req_lanes[i]`. Lane 0 covers data bits 7:0 and lane 1 covers bits 15:8. Both stay unchanged for the whole access.
- R4: A read holds `mem_oe_n`=0 and `mem_we_n`=1 for exactly the read-access count (7 cycles). It captures `mem_dq_in` on the clock edge that ends that window. It then raises `rsp_valid` for exactly one cycle, 8 cycles after acceptance.
- R5: In `rsp_rdata`, any byte lane whose `req_lanes` bit was 0 reads as zero.
- R6: A write holds `mem_we_n`=0 for exactly the strobe count (5 cycles), with the chip selected and `mem_oe_n`=1. `mem_dq_out` carries the write data with `mem_dq_oe`=1 for the whole strobe plus one hold cycle after `mem_we_n` rises. `mem_dq_oe` returns to 0 in the cycle after that.
- R7: The chip stays selected for the whole write-cycle count (7 cycles) for writes, and for the read-access count (7 cycles) for reads.
- R8: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. After `mem_oe_n` rises, at least the release count (3 cycles) passes before `mem_dq_oe` is raised.
- R9: Data written through the lane mask merges into the stored word. A later read returns the merged value.
- R10: A write never produces a `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Byte-lane enables, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 19 | Memory address pins |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_lane_n | output | 2 | Active-low byte-lane enables |
| mem_dq_out | output | 16 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | 16 | Value read from the data bus |

## Verification
The acceptance edge is counted as cycle 0. The bench then samples on falling edges, so falling edge k follows rising edge k-1. At that point the read strobe `rsp_valid` is due at k=8, and `req_ready` returns at k=11 after a read and at k=8 after a write. A pin monitor counts falling edges with the write strobe low (5), with the output enable low (7) and with the chip selected (7). It then expects the bus drive to hold for one more sample and drop on the next. It also counts samples between the output enable rising and the bus drive rising, which must be at least 3. The bench models the memory and keeps a separate shadow copy updated at request time. Each read result is compared against the shadow copy, masked by the request's lanes.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_WPULSE,
        PH_WHOLD,
        PH_WREC,
        PH_TURN
    } phase_e;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } ctl_pins_t;

    localparam ctl_pins_t PINS_IDLE = '{sel_n: 1'b1, sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    function automatic int ns_to_cycles(input int ns, input int period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic phase_selects(input phase_e ph);
        return (ph == PH_READ) || (ph == PH_WPULSE) || (ph == PH_WHOLD) || (ph == PH_WREC);
    endfunction

    function automatic ctl_pins_t pins_for(input phase_e ph);
        ctl_pins_t p;
        p = PINS_IDLE;
        if (phase_selects(ph)) begin
            p.sel_n = 1'b0;
            p.sel   = 1'b1;
        end
        case (ph)
            PH_READ:   p.oe_n  = 1'b0;
            PH_WPULSE: begin
                p.we_n  = 1'b0;
                p.dq_oe = 1'b1;
            end
            PH_WHOLD:  p.dq_oe = 1'b1;
            default:   ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_req_hold.sv
module sram_req_hold #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LANES-1:0]  lanes_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  lanes_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            lanes_q <= '0;
        end else if (load) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            lanes_q <= lanes_i;
        end
    end

endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYC   = 7,
    parameter int WP_CYC   = 5,
    parameter int REC_CYC  = 1,
    parameter int TURN_CYC = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   start_wr,
    output phase_e phase_q,
    output phase_e phase_nxt,
    output logic   capture,
    output logic   idle
);

    localparam int CNT_MAX = max_int(max_int(RD_CYC, WP_CYC), max_int(REC_CYC, TURN_CYC));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] cnt_q, cnt_nxt;

    always_comb begin
        phase_nxt = phase_q;
        cnt_nxt   = cnt_q + CNT_W'(1);
        capture   = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                cnt_nxt = '0;
                if (start) phase_nxt = start_wr ? PH_WPULSE : PH_READ;
            end
            PH_READ: begin
                if (cnt_q == CNT_W'(RD_CYC - 1)) begin
                    capture   = 1'b1;
                    cnt_nxt   = '0;
                    phase_nxt = (TURN_CYC > 0) ? PH_TURN : PH_IDLE;
                end
            end
            PH_WPULSE: begin
                if (cnt_q == CNT_W'(WP_CYC - 1)) begin
                    cnt_nxt   = '0;
                    phase_nxt = PH_WHOLD;
                end
            end
            PH_WHOLD: begin
                cnt_nxt   = '0;
                phase_nxt = (REC_CYC > 0) ? PH_WREC : PH_IDLE;
            end
            PH_WREC: begin
                if (cnt_q == CNT_W'(REC_CYC - 1)) begin
                    cnt_nxt   = '0;
                    phase_nxt = PH_IDLE;
                end
            end
            PH_TURN: begin
                if (cnt_q == CNT_W'(TURN_CYC - 1)) begin
                    cnt_nxt   = '0;
                    phase_nxt = PH_IDLE;
                end
            end
            default: begin
                cnt_nxt   = '0;
                phase_nxt = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_nxt;
            cnt_q   <= cnt_nxt;
        end
    end

    assign idle = (phase_q == PH_IDLE);

    // R4: the capture strobe only fires while a read is in progress
    assert_capture_in_read_R4: assert property (@(posedge clk) disable iff (rst)
        capture |-> (phase_q == PH_READ));

    // R6: the write strobe phase is always left through the hold phase
    assert_pulse_then_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WPULSE && phase_nxt != PH_WPULSE) |=> (phase_q == PH_WHOLD));

endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv
    import sram_ctl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase_nxt,
    input  logic              capture,
    input  logic              load,
    input  logic [LANES-1:0]  lanes_i,
    input  logic [LANES-1:0]  lanes_q,
    input  logic [DATA_W-1:0] dq_in,
    output logic              sel_n,
    output logic              sel,
    output logic              we_n,
    output logic              oe_n,
    output logic              dq_oe,
    output logic [LANES-1:0]  lane_n,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int LANE_W = DATA_W / LANES;

    ctl_pins_t        pins_q;
    logic [LANES-1:0] lane_src;
    logic [DATA_W-1:0] lane_mask;

    assign lane_src = load ? lanes_i : lanes_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane_mask
        assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{lanes_q[g]}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q    <= PINS_IDLE;
            lane_n    <= '1;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            pins_q    <= pins_for(phase_nxt);
            lane_n    <= phase_selects(phase_nxt) ? ~lane_src : '1;
            rsp_valid <= capture;
            if (capture) rsp_rdata <= dq_in & lane_mask;
        end
    end

    assign sel_n = pins_q.sel_n;
    assign sel   = pins_q.sel;
    assign we_n  = pins_q.we_n;
    assign oe_n  = pins_q.oe_n;
    assign dq_oe = pins_q.dq_oe;

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel_n && !sel && we_n && oe_n && !dq_oe && (lane_n == '1) && !rsp_valid));

    assert_no_contention_R8: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> oe_n);

    assert_write_selected_R6: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (!sel_n && sel && dq_oe));

    assert_lanes_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && $past(!sel_n)) |-> $stable(lane_n));

    assert_rvalid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_rvalid_not_write_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> we_n);

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 16,
    parameter int T_ACCESS_NS   = 70,
    parameter int T_PULSE_NS    = 50,
    parameter int T_SETUP_NS    = 30,
    parameter int T_CYCLE_NS    = 70,
    parameter int T_RELEASE_NS  = 25
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [DATA_W/8-1:0]      req_lanes,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_sel_n,
    output logic                     mem_sel,
    output logic                     mem_we_n,
    output logic                     mem_oe_n,
    output logic [DATA_W/8-1:0]      mem_lane_n,
    output logic [DATA_W-1:0]        mem_dq_out,
    output logic                     mem_dq_oe,
    input  logic [DATA_W-1:0]        mem_dq_in
);

    localparam int LANES    = DATA_W / 8;
    localparam int RD_CYC   = max_int(ns_to_cycles(T_ACCESS_NS, CLK_PERIOD_NS), 1);
    localparam int WP_CYC   = max_int(max_int(ns_to_cycles(T_PULSE_NS, CLK_PERIOD_NS),
                                              ns_to_cycles(T_SETUP_NS, CLK_PERIOD_NS)), 1);
    localparam int WC_CYC   = ns_to_cycles(T_CYCLE_NS, CLK_PERIOD_NS);
    localparam int REC_CYC  = max_int(WC_CYC - WP_CYC - 1, 0);
    localparam int TURN_CYC = ns_to_cycles(T_RELEASE_NS, CLK_PERIOD_NS);

    logic              accept;
    logic              capture;
    logic              idle;
    phase_e            phase_q, phase_nxt;
    logic [LANES-1:0]  lanes_q;

    assign accept    = req_valid && req_ready;
    assign req_ready = idle;

    sram_req_hold #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .addr_i  (req_addr),
        .wdata_i (req_wdata),
        .lanes_i (req_lanes),
        .addr_q  (mem_addr),
        .wdata_q (mem_dq_out),
        .lanes_q (lanes_q)
    );

    sram_seq #(
        .RD_CYC   (RD_CYC),
        .WP_CYC   (WP_CYC),
        .REC_CYC  (REC_CYC),
        .TURN_CYC (TURN_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .start_wr  (req_write),
        .phase_q   (phase_q),
        .phase_nxt (phase_nxt),
        .capture   (capture),
        .idle      (idle)
    );

    sram_pin_drv #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_pins (
        .clk       (clk),
        .rst       (rst),
        .phase_nxt (phase_nxt),
        .capture   (capture),
        .load      (accept),
        .lanes_i   (req_lanes),
        .lanes_q   (lanes_q),
        .dq_in     (mem_dq_in),
        .sel_n     (mem_sel_n),
        .sel       (mem_sel),
        .we_n      (mem_we_n),
        .oe_n      (mem_oe_n),
        .dq_oe     (mem_dq_oe),
        .lane_n    (mem_lane_n),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assert_busy_while_selected_R2: assert property (@(posedge clk) disable iff (rst)
        !mem_sel_n |-> !req_ready);

    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

    assert_wdata_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    assert_idle_phase_in_seq_R1: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_TURN) |-> mem_sel_n);

endmodule

// File: tb/sram_async_ctl_test.sv
module sram_async_ctl_test;

    localparam int CLK_NS     = 10;
    localparam int RD_LAT     = 8;
    localparam int RD_READY   = 11;
    localparam int WR_READY   = 8;
    localparam int PULSE_LEN  = 5;
    localparam int SEL_LEN    = 7;
    localparam int OE_LEN     = 7;
    localparam int RELEASE    = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_lanes = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_lane_n;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'hA5A5;

    int checks = 0;
    int errors = 0;

    logic [15:0] model [int];
    logic [15:0] shadow [int];

    logic        cur_write = 1'b0;
    logic [18:0] cur_addr = '0;
    logic [15:0] cur_wdata = '0;
    logic [1:0]  cur_lanes = '0;

    always #(CLK_NS/2) clk = ~clk;

    sram_async_ctl uut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_lanes  (req_lanes),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .mem_addr   (mem_addr),
        .mem_sel_n  (mem_sel_n),
        .mem_sel    (mem_sel),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_lane_n (mem_lane_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] lane_mask(input logic [1:0] lanes);
        return {{8{lanes[1]}}, {8{lanes[0]}}};
    endfunction

    function automatic logic [15:0] expect_read(input logic [18:0] a, input logic [1:0] lanes);
        logic [15:0] w;
        w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
        return w & lane_mask(lanes);
    endfunction

    // memory model and pin monitor, both on the falling edge
    int  we_run = 0;
    int  sel_run = 0;
    int  oe_run = 0;
    int  gap = 100;
    bit  hold_check = 0;
    bit  data_bad = 0;
    bit  pins_bad = 0;
    bit  prev_oe_n = 1;
    bit  prev_dq_oe = 0;

    always @(negedge clk) begin
        if (!rst) begin
            // model: write, then drive read data
            if (!mem_sel_n && mem_sel && !mem_we_n) begin
                logic [15:0] w;
                w = model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : 16'h0000;
                if (!mem_lane_n[0]) w[7:0]  = mem_dq_out[7:0];
                if (!mem_lane_n[1]) w[15:8] = mem_dq_out[15:8];
                model[int'(mem_addr)] = w;
            end
            if (!mem_sel_n && mem_sel && !mem_oe_n && mem_we_n) begin
                logic [15:0] r;
                r = model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : 16'h0000;
                mem_dq_in <= {mem_lane_n[1] ? 8'hA5 : r[15:8], mem_lane_n[0] ? 8'hA5 : r[7:0]};
            end else begin
                mem_dq_in <= 16'hA5A5;
            end

            // R6: release after hold
            if (hold_check) begin
                check(mem_dq_oe == 1'b0, "R6", "bus released after hold", mem_dq_oe, 0);
                hold_check = 0;
            end
            if (!mem_we_n) begin
                we_run++;
                if (!mem_dq_oe || mem_dq_out != cur_wdata || !mem_oe_n) data_bad = 1;
            end else if (we_run > 0) begin
                check(we_run == PULSE_LEN, "R6", "write strobe length", we_run, PULSE_LEN);
                check(!data_bad, "R6", "data driven through strobe", mem_dq_out, cur_wdata);
                check(mem_dq_oe == 1'b1 && mem_dq_out == cur_wdata, "R6", "hold cycle drive",
                      mem_dq_oe, 1);
                we_run = 0;
                data_bad = 0;
                hold_check = 1;
            end

            // R3 / R7: selection window
            if (!mem_sel_n || mem_sel) begin
                sel_run++;
                if (mem_sel_n || !mem_sel || mem_addr != cur_addr || mem_lane_n != ~cur_lanes)
                    pins_bad = 1;
            end else if (sel_run > 0) begin
                check(sel_run == SEL_LEN, "R7", "select window length", sel_run, SEL_LEN);
                check(!pins_bad, "R3", "address and lanes held", mem_addr, cur_addr);
                sel_run = 0;
                pins_bad = 0;
            end

            // R4: output enable window
            if (!mem_oe_n) oe_run++;
            else if (oe_run > 0) begin
                check(oe_run == OE_LEN, "R4", "output enable length", oe_run, OE_LEN);
                oe_run = 0;
            end

            // R8: release gap and contention
            if (mem_dq_oe && !mem_oe_n)
                check(0, "R8", "drive with output enable low", mem_dq_oe, 0);
            if (mem_oe_n && !prev_oe_n) gap = 0;
            if (mem_dq_oe && !prev_dq_oe)
                check(gap >= RELEASE, "R8", "release gap before drive", gap, RELEASE);
            if (mem_oe_n && !mem_dq_oe && gap < 100) gap++;
            prev_oe_n  = mem_oe_n;
            prev_dq_oe = mem_dq_oe;
        end
    end

    task automatic do_op(input bit wr, input logic [18:0] a, input logic [15:0] d,
                         input logic [1:0] lanes);
        int  rv_k;
        int  rdy_k;
        logic [15:0] rv_data;
        logic [15:0] exp;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_lanes = lanes;
        cur_write = wr;
        cur_addr  = a;
        cur_wdata = d;
        cur_lanes = lanes;
        exp = expect_read(a, lanes);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rv_k  = 0;
        rdy_k = 0;
        rv_data = '0;
        for (int k = 1; k <= 40; k++) begin
            if (rsp_valid && rv_k == 0) begin
                rv_k = k;
                rv_data = rsp_rdata;
            end else if (rsp_valid) begin
                rv_k = -1;
            end
            if (req_ready) begin
                rdy_k = k;
                break;
            end
            @(negedge clk);
        end
        if (wr) begin
            check(rv_k == 0, "R10", "no read strobe for write", rv_k, 0);
            check(rdy_k == WR_READY, "R2", "ready return after write", rdy_k, WR_READY);
            begin
                logic [15:0] w;
                w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
                w = (w & ~lane_mask(lanes)) | (d & lane_mask(lanes));
                shadow[int'(a)] = w;
            end
        end else begin
            check(rv_k == RD_LAT, "R4", "read strobe cycle", rv_k, RD_LAT);
            check(rv_data == exp, "R9", "read data merged and masked (R5)", rv_data, exp);
            check(rdy_k == RD_READY, "R2", "ready return after read", rdy_k, RD_READY);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [18:0] addrs [8];
        void'($urandom(32'h5EED_0017));
        addrs[0] = 19'h00000; addrs[1] = 19'h7FFFF; addrs[2] = 19'h00001; addrs[3] = 19'h40000;
        addrs[4] = 19'h3FFFF; addrs[5] = 19'h12345; addrs[6] = 19'h55555; addrs[7] = 19'h2AAAA;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(mem_sel_n == 1 && mem_sel == 0, "R1", "chip selects inactive", {mem_sel_n, mem_sel}, 2'b10);
        check(mem_we_n == 1 && mem_oe_n == 1, "R1", "strobes high", {mem_we_n, mem_oe_n}, 2'b11);
        check(mem_lane_n == 2'b11 && mem_dq_oe == 0, "R1", "lanes off, bus released",
              {mem_lane_n, mem_dq_oe}, 3'b110);
        check(req_ready == 1 && rsp_valid == 0, "R1", "ready and no response",
              {req_ready, rsp_valid}, 2'b10);

        // directed corner cases
        do_op(1, 19'h00000, 16'h1234, 2'b11);
        do_op(0, 19'h00000, 16'h0000, 2'b11);
        do_op(1, 19'h00000, 16'hABCD, 2'b10);   // R9: high lane only
        do_op(0, 19'h00000, 16'h0000, 2'b11);   // expect AB34
        do_op(0, 19'h00000, 16'h0000, 2'b01);   // R5: high lane reads zero
        do_op(0, 19'h00000, 16'h0000, 2'b10);   // R5: low lane reads zero
        do_op(1, 19'h7FFFF, 16'hFFFF, 2'b11);
        do_op(0, 19'h7FFFF, 16'h0000, 2'b11);
        do_op(1, 19'h7FFFF, 16'h0000, 2'b01);   // low lane cleared only
        do_op(0, 19'h7FFFF, 16'h0000, 2'b11);
        do_op(0, 19'h00001, 16'h0000, 2'b00);   // no lanes: zero data
        do_op(1, 19'h00001, 16'h5A5A, 2'b00);   // no lanes: nothing stored
        do_op(0, 19'h00001, 16'h0000, 2'b11);

        // constrained random mix
        for (int i = 0; i < 60; i++) begin
            bit          wr;
            logic [18:0] a;
            logic [15:0] d;
            logic [1:0]  ln;
            wr = 1'($urandom_range(0, 1));
            a  = addrs[$urandom_range(0, 7)];
            d  = 16'($urandom());
            ln = 2'($urandom_range(0, 3));
            do_op(wr, a, d, ln);
        end

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule